// File: doc/BRIEF.md
# Programmable Address Window Decoder with Remap

This block decides where a CPU physical address goes. It holds a bank of programmable windows. Each window has an enable, a 4-bit target ID, an 8-bit attribute, a size in 64 KB units and a base in a 36-bit physical address space. When an address falls inside an enabled window, the block reports a hit and returns that window's target and attribute. The leading group of windows can also remap the address. A remapped window swaps the bits above the window size for a programmed value.

Software programs the windows through a 32-bit word register port. The remappable windows use a 16-byte stride with four words each. The other windows use an 8-byte stride with two words each. A 16-byte gap with no registers in it separates the two groups. The lookup is combinational. Three checks run continuously on the programmed state: the block flags any enabled window whose size or base is malformed, it flags any pair of enabled windows that overlap, and it flags an address that lands in more than one window.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and every register reads zero. `hit`, `overlap` and `invalid` are all zero.
- R2: The control word has enable at bit 0, target at bits 7:4, attribute at bits 15:8 and (size/64 KB - 1) at bits 31:16. Bits 3:1 read back as zero.
- R3: In the base word, bits 31:16 give address bits 31:16 and bits 3:0 give address bits 35:32. All other bits read back as zero.
- R4: Window w < 8 sits at byte offset w*16, with control at +0, base at +4, remap-low at +8 and remap-high at +C. Remap-low bits 31:16 and remap-high bits 3:0 are implemented. Window w >= 8 sits at 0x90 + (w-8)*8, with control at +0 and base at +4. The block ignores byte-address bits 1:0.
- R5: Offsets 0x80 to 0x8F, and offsets at or beyond 0xF0, read zero. Writes to them change no state.
- R6: An address hits when an enabled window satisfies base <= address < base + size. The block then outputs that window's target and attribute. A disabled window never matches, and writing zero to a control word disables the window.
- R7: When several enabled windows match, the lowest-numbered one wins and `multi_hit` is 1.
- R8: When the winning window is below 8, the translated address takes bits 35:32 from remap-high. It takes bits 31:16 from remap-low for the bits at or above the window size, and from the input address for the bits below it. Bits 15:0 pass through unchanged.
- R9: A hit on a window at or above 8 passes the address through unchanged, and so does a miss.
- R10: `invalid[w]` is 1 when window w is enabled and either its size is not a power of two or its base is not a multiple of its size.
- R11: `overlap` is 1 when two enabled windows a and b satisfy base_a < end_b and end_a > base_b, where end = base + size. Windows that only touch end-to-start do not overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| lk_addr | input | 36 | Physical address to decode |
| hit | output | 1 | Address lies in an enabled window |
| hit_target | output | 4 | Target ID of the winning window |
| hit_attr | output | 8 | Attribute of the winning window |
| xlate_addr | output | 36 | Translated address |
| multi_hit | output | 1 | More than one enabled window matches |
| overlap | output | 1 | Some pair of enabled windows overlaps |
| invalid | output | NUM_WIN (20) | Per-window malformed size or base flag |

## Verification
Priority selection and remap translation act in the same cycle when an address lies in both a remappable window and a higher-numbered pass-through window. The bench provokes this by placing window 3 across the upper half of window 12. It then sweeps addresses over that region, and checks that the target, attribute and remapped address come from window 3 and that `multi_hit` and `overlap` are set together. After window 3 is disabled by a zero control write, the same sweep has to show window 12's pass-through result. A window that ends exactly where the next one begins has to leave `overlap` low.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int RAW       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RAW-1:0]     reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [35:0]        lk_addr,
  output logic               hit,
  output logic [3:0]         hit_target,
  output logic [7:0]         hit_attr,
  output logic [35:0]        xlate_addr,
  output logic               multi_hit,
  output logic               overlap,
  output logic [NUM_WIN-1:0] invalid
);
  localparam int WW      = $clog2(NUM_WIN);
  localparam int GAP_LO  = NUM_REMAP * 16;
  localparam int HI_LO   = GAP_LO + 16;
  localparam int HI_END  = HI_LO + (NUM_WIN - NUM_REMAP) * 8;

  logic [NUM_WIN-1:0] win_en;
  logic [3:0]  tgt  [NUM_WIN];
  logic [7:0]  attr [NUM_WIN];
  logic [15:0] szm1 [NUM_WIN];
  logic [15:0] blo  [NUM_WIN];
  logic [3:0]  bhi  [NUM_WIN];
  logic [15:0] rlo  [NUM_REMAP];
  logic [3:0]  rhi  [NUM_REMAP];

  logic          dec_ok;
  logic [WW-1:0] dec_win;
  logic [1:0]    dec_word;
  logic [RAW-1:0] hi_off;
  wire unused_lsb = ^reg_addr[1:0];

  assign hi_off = reg_addr - RAW'(HI_LO);

  always_comb begin
    dec_ok   = 1'b0;
    dec_win  = '0;
    dec_word = 2'd0;
    if (reg_addr < RAW'(GAP_LO)) begin
      dec_ok   = 1'b1;
      dec_win  = WW'(reg_addr[RAW-1:4]);
      dec_word = reg_addr[3:2];
    end else if (reg_addr >= RAW'(HI_LO) && reg_addr < RAW'(HI_END)) begin
      dec_ok   = 1'b1;
      dec_win  = WW'(NUM_REMAP) + WW'(hi_off[RAW-1:3]);
      dec_word = {1'b0, reg_addr[2]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en <= '0;
      for (int w = 0; w < NUM_WIN; w++) begin
        tgt[w] <= '0; attr[w] <= '0; szm1[w] <= '0; blo[w] <= '0; bhi[w] <= '0;
      end
      for (int w = 0; w < NUM_REMAP; w++) begin
        rlo[w] <= '0; rhi[w] <= '0;
      end
    end else if (reg_wr && dec_ok) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (dec_win == WW'(w)) begin
          if (dec_word == 2'd0) begin
            win_en[w] <= reg_wdata[0];
            tgt[w]    <= reg_wdata[7:4];
            attr[w]   <= reg_wdata[15:8];
            szm1[w]   <= reg_wdata[31:16];
          end
          if (dec_word == 2'd1) begin
            blo[w] <= reg_wdata[31:16];
            bhi[w] <= reg_wdata[3:0];
          end
        end
      end
      for (int w = 0; w < NUM_REMAP; w++) begin
        if (dec_win == WW'(w)) begin
          if (dec_word == 2'd2) rlo[w] <= reg_wdata[31:16];
          if (dec_word == 2'd3) rhi[w] <= reg_wdata[3:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (dec_ok) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (dec_win == WW'(w)) begin
          if (dec_word == 2'd0) reg_rdata = {szm1[w], attr[w], tgt[w], 3'b000, win_en[w]};
          if (dec_word == 2'd1) reg_rdata = {blo[w], 12'h000, bhi[w]};
        end
      end
      for (int w = 0; w < NUM_REMAP; w++) begin
        if (dec_win == WW'(w)) begin
          if (dec_word == 2'd2) reg_rdata = {rlo[w], 16'h0000};
          if (dec_word == 2'd3) reg_rdata = {28'h0, rhi[w]};
        end
      end
    end
  end

  logic [NUM_WIN-1:0] match;
  logic [36:0] wbase [NUM_WIN];
  logic [36:0] wend  [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign wbase[g] = {1'b0, bhi[g], blo[g], 16'h0000};
    assign wend[g]  = wbase[g] + {5'b0, szm1[g], 16'hFFFF} + 37'd1;
    assign match[g] = win_en[g] && ({1'b0, lk_addr} >= wbase[g]) && ({1'b0, lk_addr} < wend[g]);
    assign invalid[g] = win_en[g] &&
      (((({1'b0, szm1[g]} + 17'd1) & {1'b0, szm1[g]}) != 17'd0) || ((blo[g] & szm1[g]) != 16'd0));
  end

  logic [WW-1:0] sel;
  assign hit       = |match;
  assign multi_hit = (match & (match - 1'b1)) != '0;

  always_comb begin
    sel        = '0;
    hit_target = '0;
    hit_attr   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        sel        = WW'(w);
        hit_target = tgt[w];
        hit_attr   = attr[w];
      end
    end
    xlate_addr = lk_addr;
    for (int w = 0; w < NUM_REMAP; w++) begin
      if (hit && sel == WW'(w))
        xlate_addr[35:16] = {rhi[w], (rlo[w] & ~szm1[w]) | (lk_addr[31:16] & szm1[w])};
    end
  end

  always_comb begin
    overlap = 1'b0;
    for (int i = 0; i < NUM_WIN; i++)
      for (int j = i + 1; j < NUM_WIN; j++)
        if (win_en[i] && win_en[j] && wbase[i] < wend[j] && wend[i] > wbase[j])
          overlap = 1'b1;
  end
endmodule

module addr_window_decoder_chk #(
  parameter int RAW    = 8,
  parameter int GAP_LO = 128
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RAW-1:0] reg_addr,
  input logic [31:0]    reg_rdata,
  input logic [35:0]    lk_addr,
  input logic [35:0]    xlate_addr,
  input logic           hit,
  input logic           multi_hit,
  input logic           overlap
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!hit && !overlap));
  // R7
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> hit);
  // R11
  multi_implies_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> overlap);
  // R9
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (xlate_addr == lk_addr));
  // R5
  gap_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= RAW'(GAP_LO) && reg_addr < RAW'(GAP_LO + 16)) |-> (reg_rdata == 32'h0));
endmodule

bind addr_window_decoder addr_window_decoder_chk #(.RAW(RAW), .GAP_LO(NUM_REMAP * 16)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .lk_addr(lk_addr), .xlate_addr(xlate_addr), .hit(hit),
  .multi_hit(multi_hit), .overlap(overlap)
);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
  localparam int NW = 20;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr = '0;
  logic hit, multi_hit, overlap;
  logic [3:0] hit_target;
  logic [7:0] hit_attr;
  logic [35:0] xlate_addr;
  logic [NW-1:0] invalid;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NR];
  logic [31:0] m_rhi  [NR];

  always #5 clk = ~clk;

  addr_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .hit(hit), .hit_target(hit_target), .hit_attr(hit_attr),
    .xlate_addr(xlate_addr), .multi_hit(multi_hit), .overlap(overlap),
    .invalid(invalid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offset classification from R4/R5: w = -1 for unmapped
  function automatic void classify(input int off, output int w, output int k);
    w = -1; k = 0;
    if (off < NR * 16) begin
      w = off / 16; k = (off % 16) / 4;
    end else if (off >= NR * 16 + 16 && off < NR * 16 + 16 + (NW - NR) * 8) begin
      w = NR + (off - (NR * 16 + 16)) / 8; k = ((off - (NR * 16 + 16)) % 8) / 4;
    end
  endfunction

  function automatic logic [31:0] model_read(input int off);
    int w, k;
    classify(off, w, k);
    if (w < 0) return 32'h0;
    case (k)
      0: return m_ctrl[w];
      1: return m_base[w];
      2: return m_rlo[w];
      default: return m_rhi[w];
    endcase
  endfunction

  function automatic string req_of(input int off);
    int w, k;
    classify(off, w, k);
    if (w < 0) return "R5";
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    return "R4";
  endfunction

  task automatic clear_model();
    for (int w = 0; w < NW; w++) begin m_ctrl[w] = '0; m_base[w] = '0; end
    for (int w = 0; w < NR; w++) begin m_rlo[w] = '0; m_rhi[w] = '0; end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    int w, k;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'(off); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    classify(off, w, k);
    if (w >= 0) begin
      if (k == 0) m_ctrl[w] = d & 32'hFFFF_FFF1;
      if (k == 1) m_base[w] = d & 32'hFFFF_000F;
      if (k == 2 && w < NR) m_rlo[w] = d & 32'hFFFF_0000;
      if (k == 3 && w < NR) m_rhi[w] = d & 32'h0000_000F;
    end
  endtask

  task automatic rd_check(input int off, input string req);
    @(negedge clk);
    reg_addr = 8'(off);
    #1;
    chk(reg_rdata == model_read(off), req, 64'(reg_rdata), 64'(model_read(off)));
  endtask

  function automatic logic [36:0] m_lo(input int w);
    return {1'b0, m_base[w][3:0], m_base[w][31:16], 16'h0};
  endfunction
  function automatic logic [36:0] m_hi(input int w);
    return m_lo(w) + {5'b0, m_ctrl[w][31:16], 16'hFFFF} + 37'd1;
  endfunction

  function automatic bit m_overlap();
    for (int i = 0; i < NW; i++)
      for (int j = i + 1; j < NW; j++)
        if (m_ctrl[i][0] && m_ctrl[j][0] && m_lo(i) < m_hi(j) && m_hi(i) > m_lo(j)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [NW-1:0] m_invalid();
    logic [NW-1:0] v = '0;
    for (int w = 0; w < NW; w++) begin
      int sz = int'(m_ctrl[w][31:16]) + 1;
      bit pow2 = (sz & (sz - 1)) == 0;
      bit algn = (int'(m_base[w][31:16]) % sz) == 0;
      v[w] = m_ctrl[w][0] && !(pow2 && algn);
    end
    return v;
  endfunction

  task automatic look(input logic [35:0] a, input string req);
    int idx = -1;
    int cnt = 0;
    logic [49:0] exp, act;
    logic [35:0] xl;
    logic [15:0] m1;
    for (int w = 0; w < NW; w++)
      if (m_ctrl[w][0] && {1'b0, a} >= m_lo(w) && {1'b0, a} < m_hi(w)) begin
        cnt++;
        if (idx < 0) idx = w;
      end
    xl = a;
    if (idx >= 0 && idx < NR) begin
      m1 = m_ctrl[idx][31:16];
      xl[35:32] = m_rhi[idx][3:0];
      xl[31:16] = (m_rlo[idx][31:16] & ~m1) | (a[31:16] & m1);
    end
    if (idx >= 0) exp = {1'b1, cnt > 1, m_ctrl[idx][7:4], m_ctrl[idx][15:8], xl};
    else exp = {2'b00, 4'h0, 8'h00, xl};
    @(negedge clk);
    lk_addr = a;
    #1;
    act = {hit, multi_hit, hit_target, hit_attr, xlate_addr};
    chk(act == exp, req, 64'(act), 64'(exp));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 48; i++) begin
      logic [35:0] a = 36'(i) * 36'h10000 + 36'((i * 32'h1357) & 32'hFFFF);
      look(a, req);
    end
  endtask

  task automatic flags_check(input string req);
    @(negedge clk);
    #1;
    chk(overlap == m_overlap(), req, 64'(overlap), 64'(m_overlap()));
    chk(invalid == m_invalid(), "R10", 64'(invalid), 64'(m_invalid()));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_model();
    do_reset();
    // R1: reset state
    #1;
    chk(!hit && !overlap && invalid == '0, "R1", 64'({hit, overlap, invalid}), 64'(0));
    for (int off = 0; off < 256; off += 4) rd_check(off, "R1");

    // R2 R3 R4 R5: write every offset with a distinct pattern, then read back
    for (int off = 0; off < 256; off += 4) wr(off, 32'h9E37_79B9 * 32'(off + 1));
    for (int off = 0; off < 256; off += 4) rd_check(off, req_of(off));
    // R4: byte bits 1:0 ignored
    rd_check(8'h13, "R4");

    do_reset();
    wr(8'h00, {16'h0001, 8'h5A, 4'h3, 4'h1});
    wr(8'h04, {16'h0002, 12'h000, 4'h1});
    wr(8'h08, {16'h4000, 16'h0000});
    wr(8'h0C, 32'h0000_0002);
    wr(8'hB0, {16'h000F, 8'h33, 4'h9, 4'h1});
    wr(8'hB4, {16'h0010, 16'h0000});
    wr(8'h30, {16'h0007, 8'hC1, 4'h6, 4'h1});
    wr(8'h34, {16'h0018, 16'h0000});
    wr(8'h38, {16'h0300, 16'h0000});
    wr(8'h3C, 32'h0000_0005);
    wr(8'hC0, {16'h0000, 8'h77, 4'hE, 4'h1});
    wr(8'hC4, {16'h0020, 16'h0000});
    // R5: writes to the gap change nothing
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    rd_check(8'h80, "R5");

    flags_check("R11");
    // R6 R7 R8 R9: window 3 over window 12
    sweep("R6 R7 R8 R9");
    look(36'h1_0002_0000, "R8");
    look(36'h1_0003_FFFF, "R8");
    look(36'h1_0004_0000, "R6");
    look(36'h0_0002_0000, "R6");
    look(36'h0_001F_FFFF, "R7");
    look(36'h0_0020_0000, "R9");
    look(36'h0_0021_0000, "R6");

    // R6: zero control disables window 3; adjacent windows do not overlap (R11)
    wr(8'h30, 32'h0);
    flags_check("R11");
    sweep("R6 R9");

    // R10: malformed windows
    wr(8'h50, {16'h0002, 8'h11, 4'h2, 4'h1});
    wr(8'h54, {16'h0800, 16'h0000});
    wr(8'h98, {16'h0001, 8'h22, 4'h4, 4'h1});
    wr(8'h9C, {16'h0901, 16'h0000});
    flags_check("R11");
    look(36'h0_0902_1234, "R6");
    look(36'h0_0802_0000, "R8");
    chk(invalid[5] && invalid[9] && !invalid[0], "R10", 64'(invalid), 64'(m_invalid()));

    finish_run();
  end
endmodule